// File: doc/BRIEF.md
# Floating-Point Load/Store Decode and Address Unit

This block sits in the issue path of a core that handles floating-point memory instructions. Each cycle it takes a 32-bit instruction word with the values of the two integer registers that the instruction names. It classifies the word as a floating-point load, store, store-as-integer or "not a floating-point memory instruction". It decodes the direction, precision and base-update flags, forms the effective address and works out the access size in bytes. For update forms it also produces the write-back of the new address into the base register.

Two encodings are recognised. The displacement form uses primary opcodes 48 through 55 and a signed 16-bit offset. The indexed form uses primary opcode 31, with the flags carried in the 10-bit extended-opcode field (instruction bits 10..1). A base-register field of zero means a literal zero, not register 0. The decode is combinational and is registered once, so every result appears one clock after the instruction is presented, qualified by `out_valid`. Memory access, data format conversion and the register files are outside this block.

Top module: `fp_ldst_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid`, `out_wb_en`, `out_legal` and `out_ea` are all zero.
- R2: Displacement form (primary opcode, instruction bits 31..26, in 48..55): opcode bit 2 selects store, bit 1 selects double precision, bit 0 selects base update. The target register is bits 25..21 and the base field is bits 20..16.
- R3: Indexed form (primary opcode 31): the instruction is a floating-point load/store when extended-opcode bits 9..8 are 2'b10 and bits 4..0 are 5'b10111. Within it, extended-opcode bit 7 selects store, bit 6 selects double and bit 5 selects update.
- R4: The effective address is the sign-extended displacement (instruction bits 15..0) in the displacement form, or the index value in the indexed form. The base value is added only when the base field is non-zero. The sum wraps modulo 2^XLEN.
- R5: An update form whose base field is zero is reported as not legal, with no write-back.
- R6: A legal update form raises `out_wb_en` and sends the base field and the effective address out on the write-back port.
- R7: A legal access reports 4 bytes when single precision and 8 bytes when double.
- R8: Indexed extended opcode 983 is store-as-integer: legal, store, single (4 bytes), no update, with `out_store_int` high.
- R9: Any other primary opcode, or an opcode-31 word whose extended opcode fails the R3 test and is not 983, reports not legal. All flags are clear, the size is 0 and there is no write-back.
- R10: Instruction bit 0 (the condition-record bit) has no effect on any output.
- R11: Results appear one clock after `in_valid`. With `in_valid` low, `out_valid` and `out_wb_en` fall and every other output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and operands are present |
| in_insn | input | 32 | Instruction word |
| in_base_val | input | XLEN | Value of the register named by bits 20..16 |
| in_index_val | input | XLEN | Value of the register named by bits 15..11 |
| out_valid | output | 1 | Registered results are for a presented instruction |
| out_legal | output | 1 | Word is a legal floating-point load/store |
| out_store | output | 1 | Access writes memory |
| out_double | output | 1 | Double-precision access |
| out_update | output | 1 | Base register is updated |
| out_store_int | output | 1 | Store-as-integer variant |
| out_size | output | 4 | Access size in bytes (0 when not legal) |
| out_fpr | output | 5 | Floating-point register field |
| out_ea | output | XLEN | Effective address |
| out_wb_en | output | 1 | Write-back of the base register requested |
| out_wb_idx | output | 5 | Base register to write |
| out_wb_data | output | XLEN | Value to write (the effective address) |

## Verification
The bench builds the unit with its default XLEN of 32. At that width, negative displacements and base values near 2^32 show the wrap of the address sum, and a full-width index value shows that the displacement is not involved in the indexed form. All eight displacement opcodes and all eight indexed extended opcodes are swept with pseudo-random operands. The bench also applies the store-as-integer code, the neighbours of both opcode ranges and idle cycles between instructions, and compares each of them against a behavioural model.

// File: rtl/fp_ldst_pkg.sv
package fp_ldst_pkg;

  localparam int INSN_W    = 32;
  localparam int REG_IDX_W = 5;
  localparam int OPC_W     = 6;
  localparam int XO_W      = 10;
  localparam int DISP_W    = 16;
  localparam int SIZE_W    = 4;

  // displacement-form opcodes occupy 48..55: top three bits 110
  localparam logic [2:0]         DFORM_TOP    = 3'b110;
  localparam logic [OPC_W-1:0]   OPC_INDEXED  = 6'd31;
  localparam logic [XO_W-1:0]    XO_STORE_INT = 10'd983;
  localparam logic [1:0]         XO_FP_HI     = 2'b10;
  localparam logic [4:0]         XO_FP_LO     = 5'b10111;

  localparam logic [SIZE_W-1:0]  BYTES_SINGLE = 4'd4;
  localparam logic [SIZE_W-1:0]  BYTES_DOUBLE = 4'd8;

  typedef enum logic [1:0] {
    FORM_NONE  = 2'd0,
    FORM_DISP  = 2'd1,
    FORM_INDEX = 2'd2,
    FORM_STINT = 2'd3
  } ldst_form_e;

  typedef struct packed {
    logic                 legal;
    logic                 store;
    logic                 dbl;
    logic                 upd;
    logic                 store_int;
    logic [SIZE_W-1:0]    size;
    logic [REG_IDX_W-1:0] fpr;
    logic [REG_IDX_W-1:0] base;
  } ldst_ctrl_t;

endpackage

// File: rtl/fp_ldst_dec.sv
module fp_ldst_dec
  import fp_ldst_pkg::*;
(
  input  logic [OPC_W-1:0]     opcd,
  input  logic [REG_IDX_W-1:0] fpr_fld,
  input  logic [REG_IDX_W-1:0] base_fld,
  input  logic [XO_W-1:0]      xo,
  output ldst_ctrl_t           ctrl,
  output logic                 use_disp,
  output logic                 base_is_zero
);

  ldst_form_e form;
  logic       raw_store;
  logic       raw_dbl;
  logic       raw_upd;
  logic       bad_update;
  logic       legal;

  // classify the encoding
  always_comb begin
    form = FORM_NONE;
    if (opcd[OPC_W-1:3] == DFORM_TOP) begin
      form = FORM_DISP;
    end else if (opcd == OPC_INDEXED) begin
      if (xo == XO_STORE_INT) begin
        form = FORM_STINT;
      end else if (xo[9:8] == XO_FP_HI && xo[4:0] == XO_FP_LO) begin
        form = FORM_INDEX;
      end
    end
  end

  // pick flag bits by form
  always_comb begin
    raw_store = 1'b0;
    raw_dbl   = 1'b0;
    raw_upd   = 1'b0;
    unique case (form)
      FORM_DISP: begin
        raw_store = opcd[2];
        raw_dbl   = opcd[1];
        raw_upd   = opcd[0];
      end
      FORM_INDEX: begin
        raw_store = xo[7];
        raw_dbl   = xo[6];
        raw_upd   = xo[5];
      end
      FORM_STINT: begin
        raw_store = 1'b1;
      end
      default: ;
    endcase
  end

  assign base_is_zero = (base_fld == '0);
  assign bad_update   = raw_upd && base_is_zero;
  assign legal        = (form != FORM_NONE) && !bad_update;
  assign use_disp     = (form == FORM_DISP);

  always_comb begin
    ctrl           = '0;
    ctrl.fpr       = fpr_fld;
    ctrl.base      = base_fld;
    if (legal) begin
      ctrl.legal     = 1'b1;
      ctrl.store     = raw_store;
      ctrl.dbl       = raw_dbl;
      ctrl.upd       = raw_upd;
      ctrl.store_int = (form == FORM_STINT);
      ctrl.size      = raw_dbl ? BYTES_DOUBLE : BYTES_SINGLE;
    end
  end

endmodule

// File: rtl/fp_ldst_agen.sv
module fp_ldst_agen
  import fp_ldst_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              use_disp,
  input  logic [DISP_W-1:0] disp,
  input  logic              base_is_zero,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   index_val,
  output logic [XLEN-1:0]   ea
);

  localparam int EXT_W = (XLEN > DISP_W) ? (XLEN - DISP_W) : 1;

  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] base_term;
  logic [XLEN-1:0] offset_term;

  generate
    if (XLEN > DISP_W) begin : g_sext
      logic [EXT_W-1:0] sign_fill;
      assign sign_fill = {EXT_W{disp[DISP_W-1]}};
      assign disp_ext  = {sign_fill, disp};
    end else begin : g_trunc
      logic [DISP_W-1:0] disp_unused_hi;
      assign disp_unused_hi = disp;
      assign disp_ext       = disp[XLEN-1:0];
    end
  endgenerate

  // field value zero names a literal zero, not a register
  assign base_term   = base_is_zero ? '0 : base_val;
  assign offset_term = use_disp ? disp_ext : index_val;
  assign ea          = base_term + offset_term;

endmodule

// File: rtl/fp_ldst_oreg.sv
module fp_ldst_oreg
  import fp_ldst_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  ldst_ctrl_t      ctrl_d,
  input  logic [XLEN-1:0] ea_d,
  output logic            vld_q,
  output ldst_ctrl_t      ctrl_q,
  output logic [XLEN-1:0] ea_q
);

  logic            vld_nx;
  ldst_ctrl_t      ctrl_nx;
  logic [XLEN-1:0] ea_nx;

  // next state: load on valid, otherwise hold
  always_comb begin
    vld_nx  = in_valid;
    ctrl_nx = ctrl_q;
    ea_nx   = ea_q;
    if (in_valid) begin
      ctrl_nx = ctrl_d;
      ea_nx   = ea_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      ctrl_q <= '0;
      ea_q   <= '0;
    end else begin
      vld_q  <= vld_nx;
      ctrl_q <= ctrl_nx;
      ea_q   <= ea_nx;
    end
  end

  p_valid_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> vld_q);
  p_idle_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !vld_q);
  p_idle_holds_ea_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(ea_q));
  p_idle_holds_ctrl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(ctrl_q));

endmodule

// File: rtl/fp_ldst_unit.sv
module fp_ldst_unit
  import fp_ldst_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [INSN_W-1:0]    in_insn,
  input  logic [XLEN-1:0]      in_base_val,
  input  logic [XLEN-1:0]      in_index_val,
  output logic                 out_valid,
  output logic                 out_legal,
  output logic                 out_store,
  output logic                 out_double,
  output logic                 out_update,
  output logic                 out_store_int,
  output logic [SIZE_W-1:0]    out_size,
  output logic [REG_IDX_W-1:0] out_fpr,
  output logic [XLEN-1:0]      out_ea,
  output logic                 out_wb_en,
  output logic [REG_IDX_W-1:0] out_wb_idx,
  output logic [XLEN-1:0]      out_wb_data
);

  ldst_ctrl_t      ctrl_d;
  ldst_ctrl_t      ctrl_q;
  logic            use_disp;
  logic            base_is_zero;
  logic [XLEN-1:0] ea_d;
  logic [XLEN-1:0] ea_q;
  logic            vld_q;
  logic            rc_unused;

  // condition-record bit is never consumed by memory forms
  assign rc_unused = in_insn[0];

  fp_ldst_dec u_dec (
    .opcd         (in_insn[31:26]),
    .fpr_fld      (in_insn[25:21]),
    .base_fld     (in_insn[20:16]),
    .xo           (in_insn[10:1]),
    .ctrl         (ctrl_d),
    .use_disp     (use_disp),
    .base_is_zero (base_is_zero)
  );

  fp_ldst_agen #(.XLEN(XLEN)) u_agen (
    .use_disp     (use_disp),
    .disp         (in_insn[15:0]),
    .base_is_zero (base_is_zero),
    .base_val     (in_base_val),
    .index_val    (in_index_val),
    .ea           (ea_d)
  );

  fp_ldst_oreg #(.XLEN(XLEN)) u_oreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .ctrl_d   (ctrl_d),
    .ea_d     (ea_d),
    .vld_q    (vld_q),
    .ctrl_q   (ctrl_q),
    .ea_q     (ea_q)
  );

  assign out_valid     = vld_q;
  assign out_legal     = ctrl_q.legal;
  assign out_store     = ctrl_q.store;
  assign out_double    = ctrl_q.dbl;
  assign out_update    = ctrl_q.upd;
  assign out_store_int = ctrl_q.store_int;
  assign out_size      = ctrl_q.size;
  assign out_fpr       = ctrl_q.fpr;
  assign out_ea        = ea_q;
  assign out_wb_en     = vld_q && ctrl_q.upd;
  assign out_wb_idx    = ctrl_q.base;
  assign out_wb_data   = ea_q;

  p_wb_base_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_wb_en |-> (out_wb_idx != '0));
  p_wb_needs_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_wb_en |-> (out_valid && out_legal && out_update));
  p_size_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_legal) |-> (out_size == (out_double ? BYTES_DOUBLE : BYTES_SINGLE)));
  p_store_int_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_store_int |-> (out_store && !out_double && !out_update));
  p_illegal_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_legal) |-> (!out_store && !out_double && !out_update && out_size == '0));

endmodule

// File: tb/tb_fp_ldst_unit.sv
module tb_fp_ldst_unit;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [31:0]     in_insn;
  logic [XLEN-1:0] in_base_val;
  logic [XLEN-1:0] in_index_val;
  logic            out_valid, out_legal, out_store, out_double, out_update, out_store_int;
  logic [3:0]      out_size;
  logic [4:0]      out_fpr, out_wb_idx;
  logic [XLEN-1:0] out_ea, out_wb_data;
  logic            out_wb_en;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fp_ldst_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .in_base_val(in_base_val), .in_index_val(in_index_val),
    .out_valid(out_valid), .out_legal(out_legal), .out_store(out_store),
    .out_double(out_double), .out_update(out_update), .out_store_int(out_store_int),
    .out_size(out_size), .out_fpr(out_fpr), .out_ea(out_ea), .out_wb_en(out_wb_en),
    .out_wb_idx(out_wb_idx), .out_wb_data(out_wb_data)
  );

  typedef struct {
    bit legal, store, dbl, upd, stint;
    int size;
    int fpr, base;
    logic [31:0] ea;
  } exp_t;

  exp_t held;

  function automatic exp_t model(logic [31:0] insn, logic [31:0] a, logic [31:0] b);
    exp_t e;
    int op, x, rafld;
    bit known;
    bit use_d;
    logic [31:0] off;
    op = int'(insn[31:26]); x = int'(insn[10:1]); rafld = int'(insn[20:16]);
    e = '{default: 0};
    e.fpr = int'(insn[25:21]); e.base = rafld;
    known = 0; use_d = 0;
    if (op >= 48 && op <= 55) begin
      known = 1; use_d = 1;
      e.store = (op - 48) >= 4;
      e.dbl   = ((op - 48) % 4) >= 2;
      e.upd   = (op % 2) == 1;
    end else if (op == 31) begin
      case (x)
        535: begin known = 1; end
        567: begin known = 1; e.upd = 1; end
        599: begin known = 1; e.dbl = 1; end
        631: begin known = 1; e.dbl = 1; e.upd = 1; end
        663: begin known = 1; e.store = 1; end
        695: begin known = 1; e.store = 1; e.upd = 1; end
        727: begin known = 1; e.store = 1; e.dbl = 1; end
        759: begin known = 1; e.store = 1; e.dbl = 1; e.upd = 1; end
        983: begin known = 1; e.store = 1; e.stint = 1; end
        default: known = 0;
      endcase
    end
    if (known && e.upd && rafld == 0) known = 0;
    if (!known) begin
      e.store = 0; e.dbl = 0; e.upd = 0; e.stint = 0; e.size = 0;
    end else begin
      e.legal = 1;
      e.size = e.dbl ? 8 : 4;
    end
    if (use_d) off = {{16{insn[15]}}, insn[15:0]};
    else       off = b;
    e.ea = off + ((rafld == 0) ? 32'd0 : a);
    return e;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(bit v, logic [31:0] insn, logic [31:0] a, logic [31:0] b, string req);
    exp_t e;
    @(negedge clk);
    in_valid = v; in_insn = insn; in_base_val = a; in_index_val = b;
    if (v) begin
      e = model(insn, a, b);
      held = e;
    end else begin
      e = held;
    end
    @(posedge clk);
    #1;
    chk(out_valid == v, "R11", "valid", out_valid, v);
    chk(out_legal == e.legal, req, "legal", out_legal, e.legal);
    chk(out_store == e.store && out_double == e.dbl && out_update == e.upd &&
        out_store_int == e.stint, req, "flags",
        {out_store, out_double, out_update, out_store_int},
        {e.store, e.dbl, e.upd, e.stint});
    chk(int'(out_size) == e.size, (v ? "R7" : "R11"), "size", out_size, e.size);
    chk(out_fpr == e.fpr[4:0], req, "fpr", out_fpr, e.fpr);
    chk(out_ea == e.ea, (v ? "R4" : "R11"), "ea", out_ea, e.ea);
    chk(out_wb_en == (v && e.upd), (v ? "R6" : "R11"), "wb_en", out_wb_en, v && e.upd);
    if (v && e.upd) begin
      chk(out_wb_idx == e.base[4:0] && out_wb_data == e.ea, "R6", "wb",
          {out_wb_idx, out_wb_data}, {e.base[4:0], e.ea});
    end
  endtask

  function automatic logic [31:0] dform(int op, int rt, int ra, logic [15:0] d);
    return {op[5:0], rt[4:0], ra[4:0], d};
  endfunction

  function automatic logic [31:0] xform(int rt, int ra, int rb, int xo, bit rc);
    return {6'd31, rt[4:0], ra[4:0], rb[4:0], xo[9:0], rc};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    int xos[8];
    rst_n = 1'b0; in_valid = 0; in_insn = '0; in_base_val = '0; in_index_val = '0;
    held = '{default: 0};
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_wb_en == 0 && out_legal == 0 && out_ea == 0, "R1",
        "reset", {out_valid, out_wb_en, out_legal}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(out_valid == 0 && out_ea == 0, "R1", "after reset", out_ea, 0);

    // R2 displacement forms
    apply(1, dform(48, 2, 3, 16'h0010), 32'h1000, 32'hDEAD, "R2");
    apply(1, dform(51, 9, 5, 16'hFFF8), 32'h2000, 32'h0, "R2");
    apply(1, dform(52, 1, 0, 16'h7FF0), 32'hFFFF_0000, 32'h0, "R4");
    // R5 update with base zero
    apply(1, dform(55, 4, 0, 16'h0040), 32'h100, 32'h0, "R5");
    apply(1, xform(4, 0, 6, 567, 0), 32'h100, 32'h300, "R5");
    // R3 indexed
    apply(1, xform(7, 0, 2, 535, 0), 32'h5555, 32'h2000, "R3");
    apply(1, xform(7, 8, 2, 759, 0), 32'h4000, 32'h0123, "R3");
    // R8 store as integer
    apply(1, xform(12, 3, 4, 983, 0), 32'h10, 32'h20, "R8");
    apply(1, xform(12, 0, 4, 983, 0), 32'h10, 32'h20, "R8");
    // R9 not FP load/store
    apply(1, xform(1, 2, 3, 266, 0), 32'h1, 32'h2, "R9");
    apply(1, xform(1, 2, 3, 535 | 10'h100, 0), 32'h1, 32'h2, "R9");
    apply(1, dform(47, 1, 2, 16'h4), 32'h1, 32'h2, "R9");
    apply(1, dform(56, 1, 2, 16'h4), 32'h1, 32'h2, "R9");
    apply(1, dform(32, 1, 2, 16'h4), 32'h1, 32'h2, "R9");
    // R10 condition-record bit
    apply(1, dform(50, 3, 3, 16'h8) | 32'h1, 32'h80, 32'h0, "R10");
    apply(1, xform(3, 6, 7, 695, 1), 32'h300, 32'h44, "R10");
    apply(1, xform(3, 6, 7, 983, 1), 32'h300, 32'h44, "R10");
    // R4 wrap
    apply(1, dform(49, 2, 6, 16'h0020), 32'hFFFF_FFF0, 32'h0, "R4");
    apply(1, xform(2, 6, 9, 599, 0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
    // R11 idle cycles hold
    apply(0, dform(54, 1, 1, 16'h1), 32'h9, 32'h9, "R11");
    apply(0, 32'h0, 32'h0, 32'h0, "R11");

    // sweep both forms with pseudo-random operands
    xos = '{535, 567, 599, 631, 663, 695, 727, 759};
    lfsr = 32'hACE1_2468;
    for (int round = 0; round < 12; round++) begin
      for (int k = 0; k < 8; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        apply(1, dform(48 + k, int'(lfsr[4:0]), int'(lfsr[9:5]), lfsr[27:12]),
              lfsr ^ 32'h5A5A_0F0F, ~lfsr, "R2");
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        apply(1, xform(int'(lfsr[4:0]), int'(lfsr[9:5]), int'(lfsr[14:10]), xos[k], lfsr[15]),
              lfsr, {lfsr[15:0], lfsr[31:16]}, "R3");
        if (lfsr[3]) apply(0, lfsr, lfsr, lfsr, "R11");
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule